// File: doc/BRIEF.md
# Layered Lookup-Table Function Unit

This block is a reconfigurable execution unit placed next to the fixed arithmetic unit of a processor pipeline. Like the fixed unit, it takes two 32-bit source operands and returns one 32-bit result. Inside, the operands pass through three layers of 3-input lookup tables. Before each lookup-table input sits a programmable selection mux. A table's output reaches only the layer directly below it, so the fabric is strictly feed-forward and shallow enough to settle within one processor cycle.

Software loads the tables and mux selections through a word-wide configuration port while `cfg_valid` is low. Each configuration word describes one lookup table. Once the configuration is loaded, `cfg_valid` is raised and the unit accepts operations. On each issued operation, `sel_prog` chooses between the fabric output and a result supplied by the fixed arithmetic unit. The chosen value is registered, so it appears one cycle after issue.

Top module: `layered_pfu`

## Requirements
- R1: After a synchronous active-low reset, `result` is 0 and `res_valid` is 0. Every configuration word is cleared to 0, so every table outputs 0.
- R2: A write takes effect when `cfg_we` is 1 and `cfg_valid` is 0. Address `layer*32 + lut` selects the word for one table. The word is laid out as follows: bits [6:0] hold the source for table input 0, bits [13:7] the source for input 1, bits [20:14] the source for input 2, and bits [28:21] the truth table.
- R3: A write attempted while `cfg_valid` is 1 leaves the configuration unchanged.
- R4: Writes to addresses 96 to 127 leave the configuration unchanged.
- R5: Source codes are decoded as follows:
  - 0 to 31 select `op_a` bits 0 to 31.
  - 32 to 63 select `op_b` bits 0 to 31.
  - 64 to 95 select the outputs of tables 0 to 31 in the layer above.
  - In the top layer, codes 64 to 95 read as 0.
  - Codes 96 to 127 read as 0 in every layer.
- R6: A table's output is bit `{in2,in1,in0}` of its 8-bit truth table.
- R7: There are exactly three layers. Each layer feeds only the next one. Result bit i is the output of table i in the bottom layer.
- R8: When `issue` is 1, `sel_prog` is 1 and `cfg_valid` is 1, the next cycle shows `res_valid` at 1 and `result` equal to the fabric's output for the issued operands.
- R9: When `issue` is 1 and `sel_prog` is 0, the next cycle shows `res_valid` at 1 and `result` equal to `fixed_res`, whatever the value of `cfg_valid`.
- R10: When `issue` is 1, `sel_prog` is 1 and `cfg_valid` is 0, the next cycle shows `res_valid` at 0 and `result` unchanged.
- R11: A cycle with `issue` at 0 leaves `result` unchanged and gives `res_valid` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_valid | input | 1 | Configuration complete; blocks writes and enables the fabric path |
| cfg_addr | input | 7 | Table address, layer*32 + table index |
| cfg_wdata | input | 29 | Configuration word: three source codes and a truth table |
| issue | input | 1 | Operation issued this cycle |
| sel_prog | input | 1 | 1 selects the fabric, 0 selects the fixed result |
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand |
| fixed_res | input | 32 | Result from the fixed arithmetic unit |
| result | output | 32 | Registered result |
| res_valid | output | 1 | Result updated by an accepted operation in the previous cycle |

## Verification
The assertions assume that the control inputs `issue`, `sel_prog`, `cfg_we` and `cfg_valid` carry known two-state values from the first edge after reset. They also assume the configuration is not rewritten while an operation that depends on it is in flight. The stimulus meets both assumptions. It changes every input only on the falling clock edge. It loads each configuration fully with `cfg_valid` low, and it raises `cfg_valid` before issuing fabric operations. Stray and out-of-range writes are aimed at the configuration on purpose, and their lack of effect is observed through later results.

// File: rtl/pfu_pkg.sv
// Package pfu_pkg
// Purpose: width helpers shared by all modules of the layered function unit.
// Assumes: operand width is at least 2; lookup tables have at least 2 inputs.
package pfu_pkg;

    // Source pool per table input: operand A bits, operand B bits, previous layer.
    function automatic int src_count(input int data_w);
        return 3 * data_w;
    endfunction

    // Bits needed for one source code.
    function automatic int sel_bits(input int data_w);
        return $clog2(src_count(data_w));
    endfunction

    // Bits in one configuration word: the source codes followed by the truth table.
    function automatic int cfg_bits(input int data_w, input int lut_in);
        return lut_in * sel_bits(data_w) + (1 << lut_in);
    endfunction

    // Bits in a configuration address.
    function automatic int addr_bits(input int data_w, input int layers);
        return $clog2(layers * data_w);
    endfunction

endpackage

// File: rtl/pfu_cfg_store.sv
// Module pfu_cfg_store
// Purpose: holds one configuration word per lookup table and accepts word writes.
// Assumes: the writer holds cfg_valid low while loading; addresses at or above
//          the table count are dropped; contents clear to zero on reset.
module pfu_cfg_store #(
    parameter int DATA_W  = 32,
    parameter int LAYERS  = 3,
    parameter int CFG_W   = 29,
    parameter int ADDR_W  = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_we,
    input  logic                                  cfg_valid,
    input  logic [ADDR_W-1:0]                     cfg_addr,
    input  logic [CFG_W-1:0]                      cfg_wdata,
    output logic [LAYERS*DATA_W-1:0][CFG_W-1:0]   cfg_all
);

    localparam int              ENTRIES = LAYERS * DATA_W;
    localparam logic [ADDR_W:0] LIMIT   = (ADDR_W + 1)'(ENTRIES);

    logic in_range;
    logic wr_ok;

    // Decode whether the current write may land in storage.
    always_comb begin
        in_range = ({1'b0, cfg_addr} < LIMIT);
        wr_ok    = cfg_we && !cfg_valid && in_range;
    end

    // Configuration storage: cleared on reset, one word updated per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_all <= '0;
        end else if (wr_ok) begin
            cfg_all[cfg_addr] <= cfg_wdata;
        end
    end

    // R3: a locked configuration does not change.
    a_r3_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> $stable(cfg_all));

    // R4: out-of-range addresses do not change the configuration.
    a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cfg_addr} >= LIMIT) |=> $stable(cfg_all));

endmodule

// File: rtl/pfu_lut_cell.sv
// Module pfu_lut_cell
// Purpose: one lookup table with a programmable source mux on each input.
// Assumes: source codes beyond the pool width read as constant zero;
//          the configuration word holds the source codes (input 0 lowest)
//          followed by the truth table.
module pfu_lut_cell #(
    parameter int SRC_W  = 96,
    parameter int SEL_W  = 7,
    parameter int LUT_IN = 3,
    parameter int CFG_W  = 29
) (
    input  logic [SRC_W-1:0] pool,
    input  logic [CFG_W-1:0] cfg,
    output logic             lut_out
);

    localparam int POOL_X = 1 << SEL_W;
    localparam int TT_W   = 1 << LUT_IN;

    logic [POOL_X-1:0] pool_x;
    logic [LUT_IN-1:0] ins;
    logic [TT_W-1:0]   truth;

    // Pad the source pool so that every code has a defined value.
    always_comb begin
        pool_x            = '0;
        pool_x[SRC_W-1:0] = pool;
    end

    // One selection mux per table input.
    for (genvar k = 0; k < LUT_IN; k++) begin : g_in
        assign ins[k] = pool_x[cfg[k*SEL_W +: SEL_W]];
    end

    // Table lookup indexed by the selected inputs.
    always_comb begin
        truth   = cfg[LUT_IN*SEL_W +: TT_W];
        lut_out = truth[ins];
    end

endmodule

// File: rtl/pfu_layer.sv
// Module pfu_layer
// Purpose: one interconnect-plus-table layer of DATA_W cells.
// Assumes: prev carries the layer above (tied to zero for the top layer);
//          cells in one layer never see each other's outputs.
module pfu_layer #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 7,
    parameter int LUT_IN = 3,
    parameter int CFG_W  = 29
) (
    input  logic [DATA_W-1:0]             op_a,
    input  logic [DATA_W-1:0]             op_b,
    input  logic [DATA_W-1:0]             prev,
    input  logic [DATA_W-1:0][CFG_W-1:0]  cfg,
    output logic [DATA_W-1:0]             lay_out
);

    localparam int SRC_W = 3 * DATA_W;

    logic [SRC_W-1:0] pool;

    // Source pool ordering: operand A, operand B, previous layer.
    always_comb begin
        pool = {prev, op_b, op_a};
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_cell
        pfu_lut_cell #(
            .SRC_W  (SRC_W),
            .SEL_W  (SEL_W),
            .LUT_IN (LUT_IN),
            .CFG_W  (CFG_W)
        ) u_cell (
            .pool    (pool),
            .cfg     (cfg[i]),
            .lut_out (lay_out[i])
        );
    end

endmodule

// File: rtl/layered_pfu.sv
// Module layered_pfu
// Purpose: two-operand, one-result reconfigurable unit beside the fixed ALU.
//          A stack of LAYERS table layers computes a function of the operands;
//          the registered output chooses fabric or fixed result per issue.
// Assumes: configuration is fully loaded with cfg_valid low, then cfg_valid
//          is raised before fabric operations are issued.
module layered_pfu
    import pfu_pkg::*;
#(
    parameter  int DATA_W  = 32,
    parameter  int LAYERS  = 3,
    parameter  int LUT_IN  = 3,
    localparam int SEL_W   = sel_bits(DATA_W),
    localparam int CFG_W   = cfg_bits(DATA_W, LUT_IN),
    localparam int ADDR_W  = addr_bits(DATA_W, LAYERS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_valid,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              issue,
    input  logic              sel_prog,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] fixed_res,
    output logic [DATA_W-1:0] result,
    output logic              res_valid
);

    localparam int ENTRIES = LAYERS * DATA_W;

    logic [ENTRIES-1:0][CFG_W-1:0] cfg_all;
    logic [LAYERS:0][DATA_W-1:0]   stage;

    pfu_cfg_store #(
        .DATA_W (DATA_W),
        .LAYERS (LAYERS),
        .CFG_W  (CFG_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_valid (cfg_valid),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_all   (cfg_all)
    );

    // The top layer sees zero on its previous-layer sources.
    assign stage[0] = '0;

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        pfu_layer #(
            .DATA_W (DATA_W),
            .SEL_W  (SEL_W),
            .LUT_IN (LUT_IN),
            .CFG_W  (CFG_W)
        ) u_layer (
            .op_a    (op_a),
            .op_b    (op_b),
            .prev    (stage[l]),
            .cfg     (cfg_all[l*DATA_W +: DATA_W]),
            .lay_out (stage[l+1])
        );
    end

    // Result register: fixed path always, fabric path only once configured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= issue && (!sel_prog || cfg_valid);
            if (issue && !sel_prog) begin
                result <= fixed_res;
            end else if (issue && cfg_valid) begin
                result <= stage[LAYERS];
            end
        end
    end

    // R9: fixed selection returns the fixed unit's value one cycle later.
    a_r9_fixed_path: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !sel_prog) |=> (res_valid && result == $past(fixed_res)));

    // R10: fabric selection without a complete configuration is refused.
    a_r10_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && sel_prog && !cfg_valid) |=> (!res_valid && $stable(result)));

    // R11: idle cycles hold the result and flag nothing.
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!res_valid && $stable(result)));

endmodule

// File: tb/sim_layered_pfu.sv
module sim_layered_pfu;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic        cfg_valid;
    logic [6:0]  cfg_addr;
    logic [28:0] cfg_wdata;
    logic        issue;
    logic        sel_prog;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [31:0] fixed_res;
    logic [31:0] result;
    logic        res_valid;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [28:0] mir [96];

    always #(CLK_P/2) clk = ~clk;

    layered_pfu u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_valid (cfg_valid),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .issue     (issue),
        .sel_prog  (sel_prog),
        .op_a      (op_a),
        .op_b      (op_b),
        .fixed_res (fixed_res),
        .result    (result),
        .res_valid (res_valid)
    );

    // Build a configuration word: source codes then truth table (R2).
    function automatic logic [28:0] mkw(input int s0, input int s1, input int s2, input logic [7:0] tt);
        return {tt, 7'(s2), 7'(s1), 7'(s0)};
    endfunction

    // Reference model of the three-layer fabric (R5, R6, R7).
    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
        logic [31:0]  prev;
        logic [31:0]  nxt;
        logic [127:0] pool;
        logic [28:0]  w;
        logic [2:0]   idx;
        prev = '0;
        for (int l = 0; l < 3; l++) begin
            pool = {32'b0, prev, b, a};
            for (int i = 0; i < 32; i++) begin
                w      = mir[l*32 + i];
                idx    = {pool[w[20:14]], pool[w[13:7]], pool[w[6:0]]};
                nxt[i] = w[21 + idx];
            end
            prev = nxt;
        end
        return prev;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One configuration write; the mirror follows the rules of R2, R3, R4.
    task automatic wr(input int addr, input logic [28:0] word);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 7'(addr);
        cfg_wdata = word;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!cfg_valid && addr < 96) mir[addr] = word;
    endtask

    // One issued operation; sampled on the falling edge after the capturing edge.
    task automatic op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] fx, input logic sp);
        @(negedge clk);
        op_a = a; op_b = b; fixed_res = fx; sel_prog = sp; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
    endtask

    // Layers 1 and 2 pass table i of the layer above straight through.
    task automatic load_pass_lower();
        for (int i = 0; i < 32; i++) begin
            wr(32 + i, mkw(64 + i, 0, 0, 8'hAA));
            wr(64 + i, mkw(64 + i, 0, 0, 8'hAA));
        end
    endtask

    task automatic t_reset();
        chk("R1 result after reset", result, 32'h0);
        chk("R1 res_valid after reset", {31'b0, res_valid}, 32'h0);
        cfg_valid = 1'b1;
        op(32'hFFFF_FFFF, 32'h1234_5678, 32'h0, 1'b1);
        chk("R1 cleared tables give zero", result, 32'h0);
        chk("R8 res_valid on fabric issue", {31'b0, res_valid}, 32'h1);
    endtask

    task automatic t_bitwise();
        logic [31:0] a;
        logic [31:0] b;
        cfg_valid = 1'b0;
        for (int i = 0; i < 32; i++) wr(i, mkw(i, 32 + i, 0, 8'h88));
        load_pass_lower();
        cfg_valid = 1'b1;
        for (int n = 0; n < 4; n++) begin
            a = $urandom; b = $urandom;
            op(a, b, 32'h0, 1'b1);
            chk("R2 R6 R7 R8 bitwise AND", result, a & b);
        end
        cfg_valid = 1'b0;
        for (int i = 0; i < 32; i++) wr(i, mkw(i, 32 + i, 0, 8'h66));
        cfg_valid = 1'b1;
        op(32'hF0F0_1234, 32'h0FF0_FFFF, 32'h0, 1'b1);
        chk("R6 bitwise XOR", result, 32'hF0F0_1234 ^ 32'h0FF0_FFFF);
        op(32'h0, 32'h0, 32'h0, 1'b1);
        chk("R6 XOR of zeros", result, 32'h0);
    endtask

    task automatic t_const_sources();
        cfg_valid = 1'b0;
        for (int i = 0; i < 32; i++) wr(i, mkw((i % 2) ? 70 : 120, 0, 0, 8'hAA));
        for (int i = 0; i < 32; i++) wr(32 + i, mkw(64 + i, 0, 0, 8'h55));
        cfg_valid = 1'b1;
        op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b1);
        chk("R5 top-layer previous and high codes read zero", result, 32'hFFFF_FFFF);
        chk("R5 model agrees", result, model(32'hFFFF_FFFF, 32'hFFFF_FFFF));
    endtask

    task automatic t_locked();
        logic [31:0] a;
        a = 32'h5A5A_C3C3;
        cfg_valid = 1'b1;
        for (int i = 0; i < 32; i++) wr(64 + i, mkw(0, 0, 0, 8'h00));
        op(a, ~a, 32'h0, 1'b1);
        chk("R3 writes while locked ignored", result, model(a, ~a));
    endtask

    task automatic t_oob();
        logic [31:0] a;
        a = 32'h0137_BEEF;
        cfg_valid = 1'b0;
        for (int k = 96; k < 128; k++) wr(k, mkw(0, 0, 0, 8'hFF));
        cfg_valid = 1'b1;
        op(a, 32'h8000_0001, 32'h0, 1'b1);
        chk("R4 out-of-range writes ignored", result, model(a, 32'h8000_0001));
    endtask

    task automatic t_fixed();
        cfg_valid = 1'b0;
        op(32'h1, 32'h2, 32'hCAFE_F00D, 1'b0);
        chk("R9 fixed result unconfigured", result, 32'hCAFE_F00D);
        chk("R9 res_valid", {31'b0, res_valid}, 32'h1);
        cfg_valid = 1'b1;
        op(32'h1, 32'h2, 32'h0BAD_0001, 1'b0);
        chk("R9 fixed result configured", result, 32'h0BAD_0001);
    endtask

    task automatic t_unconfigured();
        cfg_valid = 1'b0;
        op(32'hFFFF_0000, 32'h1111_2222, 32'h7777_7777, 1'b1);
        chk("R10 res_valid low", {31'b0, res_valid}, 32'h0);
        chk("R10 result held", result, 32'h0BAD_0001);
        cfg_valid = 1'b1;
    endtask

    task automatic t_idle();
        logic [31:0] held;
        op(32'h0F0F_0F0F, 32'h3333_3333, 32'h0, 1'b1);
        held = result;
        @(negedge clk);
        op_a = 32'hDEAD_BEEF; op_b = 32'h1; fixed_res = 32'h2; sel_prog = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 result held while idle", result, held);
        chk("R11 res_valid low while idle", {31'b0, res_valid}, 32'h0);
    endtask

    task automatic t_random();
        logic [31:0] a;
        logic [31:0] b;
        for (int c = 0; c < 4; c++) begin
            cfg_valid = 1'b0;
            for (int k = 0; k < 96; k++) wr(k, 29'($urandom));
            cfg_valid = 1'b1;
            for (int n = 0; n < 20; n++) begin
                a = $urandom; b = $urandom;
                op(a, b, 32'h0, 1'b1);
                chk("R7 R8 random configuration", result, model(a, b));
            end
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 96; k++) mir[k] = '0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_valid = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        issue = 1'b0; sel_prog = 1'b0; op_a = '0; op_b = '0; fixed_res = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bitwise();
        t_const_sources();
        t_locked();
        t_oob();
        t_fixed();
        t_unconfigured();
        t_idle();
        t_random();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule